// File: doc/BRIEF.md
# Module Enable and DMA Routing Register

This block holds a 16-bit configuration word that software writes to switch peripheral modules on and off. Each used bit drives one module enable output. While a bit is 0, the module is kept idle and receives a registered, active-high reset.

Three of the bits also steer DMA routing. For each of three DMA channels, they choose where the request and interrupt come from: an external pin source or the internal module source. The counter enable bit is sticky. Once software sets it, only a hardware reset can clear it.

Access uses a plain write port with one strobe per byte. The read port returns the current word in the same cycle the read is raised.

Top module: `modcfg_ctrl`

## Requirements
- R1: The enable outputs mirror register bits 5..0, which software writes through byte lane 0. The bit assignments are: bit 0 counter, bit 1 print head, bit 2 bitmap shifter, bit 3 scanner, bit 4 scanner-on-channel-0, bit 5 codec. The outputs update on the clock edge that accepts the write.
- R2: Once bit 0 is 1, a write of 0 to it leaves it at 1.
- R3: Bits 15..6 are reserved. They ignore writes and always read as 0.
- R4: A write with the strobe for byte lane 0 low leaves every enable bit unchanged.
- R5: While the read strobe is high, the read data equals the current register value in that same cycle. While the read strobe is low, the read data is 0.
- R6: Each module reset output is registered. It equals the inverse of its enable bit as that bit stood one clock earlier, so a reset drops one cycle after its enable rises.
- R7: DMA channel 0 takes request and interrupt from the external pins when bit 4 is 0, and from the internal module source when bit 4 is 1.
- R8: DMA channel 1 takes request and interrupt from the external pins when bit 2 is 0, and from the internal module source when bit 2 is 1.
- R9: DMA channel 2 takes request and interrupt from the external pins when bit 3 is 0, and from the internal module source when bit 3 is 1.
- R10: A hardware reset clears all enable bits, including the sticky one, on the next edge, and drives every module reset output to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 2 | Per-byte write strobes |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, valid in the cycle of rd_en |
| mod_en | output | 6 | Module enable outputs |
| mod_rst | output | 6 | Module reset outputs, active high |
| ext_req | input | 3 | DMA requests from external pins, per channel |
| ext_irq | input | 3 | Interrupts from external pins, per channel |
| int_req | input | 3 | DMA requests from internal modules, per channel |
| int_irq | input | 3 | Interrupts from internal modules, per channel |
| dma_req | output | 3 | Routed DMA request, per channel |
| dma_irq | output | 3 | Routed interrupt, per channel |

## Verification
The bench uses the default 16-bit register width, which gives two byte lanes. With two lanes, the reserved upper lane can be written on its own, and a write with only the upper strobe can be shown to leave the enables untouched. For each channel, the external and internal sources are driven with differing patterns. Each channel is then observed under both settings of its select bit, both singly and with all three selects raised together. The sticky bit is cleared only by pulsing the hardware reset in mid-run.

// File: rtl/modcfg_pkg.sv
package modcfg_pkg;

    localparam int NUM_MOD = 6;
    localparam int NUM_CH  = 3;

    localparam int BIT_COUNTER   = 0;
    localparam int BIT_PRINTHEAD = 1;
    localparam int BIT_BITMAP    = 2;
    localparam int BIT_SCANNER   = 3;
    localparam int BIT_SCAN_CH0  = 4;
    localparam int BIT_CODEC     = 5;

    // Field order places the counter enable at bit 0.
    typedef struct packed {
        logic codec;
        logic scan_ch0;
        logic scanner;
        logic bitmap;
        logic printhead;
        logic counter;
    } mod_en_t;

    // Route select per channel: ch2 <- scanner, ch1 <- bitmap, ch0 <- scan_ch0.
    function automatic logic [NUM_CH-1:0] chan_sel(mod_en_t e);
        return {e.scanner, e.bitmap, e.scan_ch0};
    endfunction

    // Next value for a write to byte lane 0; the counter enable only sets.
    function automatic mod_en_t apply_write(mod_en_t cur, logic [NUM_MOD-1:0] wbits);
        mod_en_t nxt;
        nxt         = mod_en_t'(wbits);
        nxt.counter = cur.counter | wbits[BIT_COUNTER];
        return nxt;
    endfunction

endpackage

// File: rtl/modcfg_reg.sv
module modcfg_reg
    import modcfg_pkg::*;
#(
    parameter int REG_W = 16,
    localparam int NUM_BE = REG_W / 8
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              wr_en,
    input  logic [NUM_BE-1:0] wr_be,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rd_data,
    output mod_en_t           cfg
);

    mod_en_t cfg_q;
    logic    lane0_wr;

    assign lane0_wr = wr_en & wr_be[0];

    always_ff @(posedge clk) begin
        if (srst) begin
            cfg_q <= '0;
        end else if (lane0_wr) begin
            cfg_q <= apply_write(cfg_q, wr_data[NUM_MOD-1:0]);
        end
    end

    // Reserved positions are zero-extended on read.
    assign rd_data = rd_en ? REG_W'(cfg_q) : '0;
    assign cfg     = cfg_q;

    // Upper lanes and bits above the used field carry no storage.
    logic unused_hi;
    assign unused_hi = &{1'b0, wr_data[REG_W-1:NUM_MOD], wr_be[NUM_BE-1:1]};

endmodule

// File: rtl/modcfg_rstgen.sv
module modcfg_rstgen #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         srst,
    input  logic [N-1:0] en,
    output logic [N-1:0] rst
);

    logic [N-1:0] rst_q;

    always_ff @(posedge clk) begin
        if (srst) begin
            rst_q <= '1;
        end else begin
            rst_q <= ~en;
        end
    end

    assign rst = rst_q;

endmodule

// File: rtl/modcfg_dma_route.sv
module modcfg_dma_route #(
    parameter int N = 3
) (
    input  logic [N-1:0] sel,
    input  logic [N-1:0] ext_req,
    input  logic [N-1:0] ext_irq,
    input  logic [N-1:0] int_req,
    input  logic [N-1:0] int_irq,
    output logic [N-1:0] dma_req,
    output logic [N-1:0] dma_irq
);

    for (genvar c = 0; c < N; c++) begin : g_ch
        assign dma_req[c] = sel[c] ? int_req[c] : ext_req[c];
        assign dma_irq[c] = sel[c] ? int_irq[c] : ext_irq[c];
    end

endmodule

// File: rtl/modcfg_ctrl.sv
module modcfg_ctrl
    import modcfg_pkg::*;
#(
    parameter int REG_W = 16,
    localparam int NUM_BE = REG_W / 8
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              wr_en,
    input  logic [NUM_BE-1:0] wr_be,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rd_data,
    output logic [NUM_MOD-1:0] mod_en,
    output logic [NUM_MOD-1:0] mod_rst,
    input  logic [NUM_CH-1:0] ext_req,
    input  logic [NUM_CH-1:0] ext_irq,
    input  logic [NUM_CH-1:0] int_req,
    input  logic [NUM_CH-1:0] int_irq,
    output logic [NUM_CH-1:0] dma_req,
    output logic [NUM_CH-1:0] dma_irq
);

    mod_en_t           cfg;
    logic [NUM_CH-1:0] sel;

    modcfg_reg #(.REG_W(REG_W)) u_reg (
        .clk     (clk),
        .srst    (srst),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    assign mod_en = cfg;
    assign sel    = chan_sel(cfg);

    modcfg_rstgen #(.N(NUM_MOD)) u_rstgen (
        .clk  (clk),
        .srst (srst),
        .en   (mod_en),
        .rst  (mod_rst)
    );

    modcfg_dma_route #(.N(NUM_CH)) u_route (
        .sel     (sel),
        .ext_req (ext_req),
        .ext_irq (ext_irq),
        .int_req (int_req),
        .int_irq (int_irq),
        .dma_req (dma_req),
        .dma_irq (dma_irq)
    );

endmodule

// File: rtl/modcfg_ctrl_chk.sv
module modcfg_ctrl_chk #(
    parameter int REG_W = 16,
    parameter int NM    = 6,
    parameter int NC    = 3
) (
    input logic          clk,
    input logic          srst,
    input logic          rd_en,
    input logic [REG_W-1:0] rd_data,
    input logic [NM-1:0] mod_en,
    input logic [NM-1:0] mod_rst,
    input logic [NC-1:0] ext_req,
    input logic [NC-1:0] ext_irq,
    input logic [NC-1:0] int_req,
    input logic [NC-1:0] int_irq,
    input logic [NC-1:0] dma_req,
    input logic [NC-1:0] dma_irq
);

    assert_counter_sticky_R2: assert property (@(posedge clk) disable iff (srst)
        mod_en[0] |=> mod_en[0]);

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (srst)
        rd_en |-> (rd_data[REG_W-1:NM] == '0));

    assert_idle_read_R5: assert property (@(posedge clk) disable iff (srst)
        !rd_en |-> (rd_data == '0));

    assert_rst_lag_R6: assert property (@(posedge clk) disable iff (srst)
        !srst |=> (mod_rst == ~$past(mod_en)));

    assert_ch0_route_R7: assert property (@(posedge clk) disable iff (srst)
        {dma_req[0], dma_irq[0]} == (mod_en[4] ? {int_req[0], int_irq[0]} : {ext_req[0], ext_irq[0]}));

    assert_ch1_route_R8: assert property (@(posedge clk) disable iff (srst)
        {dma_req[1], dma_irq[1]} == (mod_en[2] ? {int_req[1], int_irq[1]} : {ext_req[1], ext_irq[1]}));

    assert_ch2_route_R9: assert property (@(posedge clk) disable iff (srst)
        {dma_req[2], dma_irq[2]} == (mod_en[3] ? {int_req[2], int_irq[2]} : {ext_req[2], ext_irq[2]}));

    assert_hw_clear_R10: assert property (@(posedge clk)
        srst |=> ((mod_en == '0) && (mod_rst == '1)));

endmodule

bind modcfg_ctrl modcfg_ctrl_chk #(
    .REG_W (REG_W),
    .NM    (modcfg_pkg::NUM_MOD),
    .NC    (modcfg_pkg::NUM_CH)
) u_chk (
    .clk     (clk),
    .srst    (srst),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .mod_en  (mod_en),
    .mod_rst (mod_rst),
    .ext_req (ext_req),
    .ext_irq (ext_irq),
    .int_req (int_req),
    .int_irq (int_irq),
    .dma_req (dma_req),
    .dma_irq (dma_irq)
);

// File: tb/modcfg_ctrl_bench.sv
module modcfg_ctrl_bench;

    logic        clk = 1'b0;
    logic        srst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic [5:0]  mod_en;
    logic [5:0]  mod_rst;
    logic [2:0]  ext_req = '0;
    logic [2:0]  ext_irq = '0;
    logic [2:0]  int_req = '0;
    logic [2:0]  int_irq = '0;
    logic [2:0]  dma_req;
    logic [2:0]  dma_irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    modcfg_ctrl u_modcfg_ctrl (
        .clk(clk), .srst(srst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .mod_en(mod_en), .mod_rst(mod_rst),
        .ext_req(ext_req), .ext_irq(ext_irq), .int_req(int_req), .int_irq(int_irq),
        .dma_req(dma_req), .dma_irq(dma_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; wr_data = '0;
    endtask

    task automatic rd_check(input string req, input logic [15:0] exp);
        rd_en = 1'b1;
        #1;
        check(req, 32'(rd_data), 32'(exp));
        rd_en = 1'b0;
    endtask

    // Routing model: ch0 follows bit 4, ch1 bit 2, ch2 bit 3; 1 picks internal.
    task automatic dma_check(input string req);
        logic [2:0] s;
        s = {mod_en[3], mod_en[2], mod_en[4]};
        ext_req = 3'b101; int_req = 3'b010; ext_irq = 3'b011; int_irq = 3'b100;
        #1;
        check(req, 32'(dma_req), 32'((s & int_req) | (~s & ext_req)));
        check(req, 32'(dma_irq), 32'((s & int_irq) | (~s & ext_irq)));
        ext_req = 3'b010; int_req = 3'b101; ext_irq = 3'b100; int_irq = 3'b011;
        #1;
        check(req, 32'(dma_req), 32'((s & int_req) | (~s & ext_req)));
        check(req, 32'(dma_irq), 32'((s & int_irq) | (~s & ext_irq)));
    endtask

    task automatic t_reset();
        check("R10 en after reset", 32'(mod_en), 32'h00);
        check("R10 rst after reset", 32'(mod_rst), 32'h3F);
        rd_check("R5 read after reset", 16'h0000);
    endtask

    task automatic t_enable_bits();
        wr(16'h003E, 2'b01);
        check("R1 enables", 32'(mod_en), 32'h3E);
        rd_check("R5 read value", 16'h003E);
        @(negedge clk);
        check("R6 rst follows", 32'(mod_rst), 32'h01);
    endtask

    task automatic t_sticky();
        wr(16'h0001, 2'b01);
        check("R1 single bit", 32'(mod_en), 32'h01);
        wr(16'h0000, 2'b01);
        check("R2 counter sticky", 32'(mod_en), 32'h01);
    endtask

    task automatic t_reserved();
        wr(16'hFFFF, 2'b11);
        rd_check("R3 reserved read zero", 16'h003F);
    endtask

    task automatic t_strobe();
        wr(16'h0000, 2'b10);
        check("R4 upper lane only", 32'(mod_en), 32'h3F);
        wr(16'h0000, 2'b00);
        check("R4 no strobe", 32'(mod_en), 32'h3F);
    endtask

    task automatic t_read_idle();
        #1;
        check("R5 idle read zero", 32'(rd_data), 32'h0);
    endtask

    task automatic t_rst_timing();
        wr(16'h003B, 2'b01);
        check("R6 en dropped", 32'(mod_en), 32'h3B);
        check("R6 rst not yet", 32'(mod_rst), 32'h00);
        @(negedge clk);
        check("R6 rst raised", 32'(mod_rst), 32'h04);
        wr(16'h003F, 2'b01);
        check("R6 rst held one cycle", 32'(mod_rst), 32'h04);
        @(negedge clk);
        check("R6 rst released", 32'(mod_rst), 32'h00);
    endtask

    task automatic t_hw_reset();
        @(negedge clk);
        srst = 1'b1;
        @(negedge clk);
        check("R10 en cleared", 32'(mod_en), 32'h00);
        check("R10 rst forced", 32'(mod_rst), 32'h3F);
        srst = 1'b0;
        wr(16'h0000, 2'b01);
        check("R10 sticky cleared", 32'(mod_en), 32'h00);
    endtask

    task automatic t_dma();
        dma_check("R7 R8 R9 all external");
        wr(16'h0010, 2'b01);
        dma_check("R7 ch0 internal");
        wr(16'h0004, 2'b01);
        dma_check("R8 ch1 internal");
        wr(16'h0008, 2'b01);
        dma_check("R9 ch2 internal");
        wr(16'h001C, 2'b01);
        dma_check("R7 R8 R9 all internal");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        srst = 1'b0;
        t_reset();
        t_enable_bits();
        t_sticky();
        t_reserved();
        t_strobe();
        t_read_idle();
        t_rst_timing();
        t_hw_reset();
        t_dma();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule